// File: doc/BRIEF.md
# Multichannel ADC Sampling Engine Controller

This block sequences conversions for a sixteen-input analog-to-digital converter front end. Software programs a control word, which holds the engine enable, a three-bit operating mode and one enable bit per channel. It also programs a clock word, which holds two cascaded divisors. A prescaler divides the system clock and a scaler divides the prescaler's output. Each conversion occupies twelve scaler periods.

The engine leaves power-down or standby only when it is enabled with the run mode selected. It then waits a fixed number of scaler periods before it raises a ready flag. After that, it walks the enabled channels in rising index order and wraps back to the lowest one. For each channel it holds a request to the converter for one full slot and captures the converter's 10-bit data at the end of the slot. Results are packed two per 32-bit word. The even channel sits in the low half and the odd channel in the high half.

Register accesses are 32-bit aligned. A read returns data on the clock after it is requested.

Top module: `adc_seq_top`

## Requirements
- R1: After reset every register reads zero, which means power-down with the engine disabled. The request output is low and the ready flag (control bit 8) is clear.
- R2: The control word at offset 0x00 has these fields: enable in bit 0, mode in bits 3:1 (000 power-down, 001 standby, 111 run) and channel enables in bits 31:16 (bit 16+n for channel n). Bit 8 is read-only and every other bit reads zero.
- R3: The clock word at offset 0x0C holds the prescaler divisor in bits 31:17 and the scaler divisor in bits 9:0. All other bits read zero. Each stage divides its input by its field value plus one.
- R4: No conversion request is issued unless enable is 1, the mode is 111 and the ready flag is set. In standby (001) and power-down (000) the request output stays low.
- R5: The ready flag sets 4 scaler periods after the engine enters run mode while enabled. It clears once the mode leaves 111 or enable drops.
- R6: The request for one channel stays high for exactly 12·(P+1)·(S+1) clocks, where P is the prescaler field and S is the scaler field.
- R7: Channels are visited in ascending index order, disabled channels are skipped, and the visit wraps from the highest enabled channel to the lowest. The channel output is held steady for the whole request.
- R8: At the end of a slot, the converter data is stored as that channel's result. Channel n reads as a 16-bit value at byte offset 0x10+2n: the word at 0x10+4k carries channel 2k in bits 15:0 and channel 2k+1 in bits 31:16. Result bits above bit 9 in each half read zero.
- R9: The result of a channel whose enable is clear is never updated.
- R10: While the engine is in standby or power-down, all results keep their last values whatever the converter presents.
- R11: Misaligned accesses and accesses above offset 0xC0 have no effect and read zero. Aligned unmapped offsets also read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the clock after the read strobe |
| adcReq | output | 1 | Conversion request, high for a whole slot |
| adcChan | output | 4 | Channel being converted |
| adcData | input | 10 | Converter result, sampled at the end of the slot |

## Verification
The hardest situation to reach from the ports is the wrap of the sequencer across a sparse enable mask, combined with a slot length that depends on both divisors. The stimulus programs a sparse mask (channels 2, 5 and 15) and then a full mask. A port monitor logs the channel at every rising request and times each request. The same run is repeated under three divisor settings. Freezing the engine in standby while changing the converter model's data then shows that results are held.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 16;
  localparam int CH_W   = $clog2(NUM_CH);

  localparam logic [2:0] MODE_OFF  = 3'b000;
  localparam logic [2:0] MODE_STBY = 3'b001;
  localparam logic [2:0] MODE_RUN  = 3'b111;

  // strobes from the sequencer to the result store
  typedef struct packed {
    logic            capture;
    logic [CH_W-1:0] chan;
  } seq_strobe_t;
endpackage

// File: rtl/adc_div_stage.sv
module adc_div_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inTick,
  input  logic [W-1:0] divisor,
  output logic         outTick
);
  logic [W-1:0] cnt;
  logic         atEnd;

  assign atEnd   = (cnt >= divisor);
  assign outTick = inTick && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (inTick) cnt <= atEnd ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int ADDR_W     = 8,
  parameter int PRE_W      = 15,
  parameter int PRE_LSB    = 17,
  parameter int SC_W       = 10,
  parameter int SLOT_TICKS = 12,
  parameter int INIT_TICKS = 4,
  parameter logic [ADDR_W-1:0] ENG_OFF = 'h00,
  parameter logic [ADDR_W-1:0] CLK_OFF = 'h0C,
  parameter logic [ADDR_W-1:0] TOP_OFF = 'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       engWord,
  output logic [31:0]       clkWord,
  output logic              active,
  output logic              initRdy,
  output seq_strobe_t       strb,
  output logic              adcReq,
  output logic [CH_W-1:0]   adcChan
);
  localparam int SLOT_W = $clog2(SLOT_TICKS);
  localparam int INIT_W = $clog2(INIT_TICKS + 1);

  logic              engEn;
  logic [2:0]        engMode;
  logic [NUM_CH-1:0] chanEn;
  logic [PRE_W-1:0]  preDiv;
  logic [SC_W-1:0]   scDiv;
  logic              wrHit;

  assign wrHit = wrEn && (addr[1:0] == 2'b00) && (addr <= TOP_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engEn   <= 1'b0;
      engMode <= MODE_OFF;
      chanEn  <= '0;
      preDiv  <= '0;
      scDiv   <= '0;
    end else if (wrHit) begin
      if (addr == ENG_OFF) begin
        engEn   <= wrData[0];
        engMode <= wrData[3:1];
        chanEn  <= wrData[16 +: NUM_CH];
      end
      if (addr == CLK_OFF) begin
        preDiv <= wrData[PRE_LSB +: PRE_W];
        scDiv  <= wrData[SC_W-1:0];
      end
    end
  end

  always_comb begin
    engWord              = '0;
    engWord[0]           = engEn;
    engWord[3:1]         = engMode;
    engWord[8]           = initRdy;
    engWord[16 +: NUM_CH] = chanEn;
    clkWord              = '0;
    clkWord[PRE_LSB +: PRE_W] = preDiv;
    clkWord[SC_W-1:0]    = scDiv;
  end

  assign active = engEn && (engMode == MODE_RUN);

  // cascaded dividers, restarted while idle and at every slot start
  logic divClear, preTick, scTick;
  logic slotStart, slotEnd, running;

  assign divClear = !active || slotStart;

  adc_div_stage #(.W(PRE_W)) uPre (
    .clk(clk), .rstN(rstN), .clear(divClear), .inTick(1'b1),
    .divisor(preDiv), .outTick(preTick)
  );

  adc_div_stage #(.W(SC_W)) uScl (
    .clk(clk), .rstN(rstN), .clear(divClear), .inTick(preTick),
    .divisor(scDiv), .outTick(scTick)
  );

  // start-up wait
  logic [INIT_W-1:0] initCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
      initRdy <= 1'b0;
    end else if (!active) begin
      initCnt <= '0;
      initRdy <= 1'b0;
    end else if (!initRdy && scTick) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == INIT_W'(INIT_TICKS - 1)) initRdy <= 1'b1;
    end
  end

  // round-robin pick of the next enabled channel at or after ptr
  logic [CH_W-1:0]   ptr, curChan, pickChan;
  logic              pickHit, busy;
  logic [SLOT_W-1:0] slotCnt;

  always_comb begin
    pickHit  = 1'b0;
    pickChan = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (!pickHit && chanEn[CH_W'(int'(ptr) + k)]) begin
        pickHit  = 1'b1;
        pickChan = CH_W'(int'(ptr) + k);
      end
    end
  end

  assign running   = active && initRdy;
  assign slotStart = running && !busy && pickHit;
  assign slotEnd   = running && busy && scTick && (slotCnt == SLOT_W'(SLOT_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      ptr     <= '0;
      curChan <= '0;
      slotCnt <= '0;
    end else if (!running) begin
      busy    <= 1'b0;
      ptr     <= '0;
      slotCnt <= '0;
    end else if (slotStart) begin
      busy    <= 1'b1;
      curChan <= pickChan;
      slotCnt <= '0;
    end else if (busy && scTick) begin
      if (slotEnd) begin
        busy    <= 1'b0;
        ptr     <= curChan + 1'b1;
        slotCnt <= '0;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  assign strb.capture = slotEnd;
  assign strb.chan    = curChan;
  assign adcReq       = busy;
  assign adcChan      = curChan;
endmodule

// File: rtl/adc_seq_data.sv
module adc_seq_data import adc_seq_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int RES_W  = 10,
  parameter logic [ADDR_W-1:0] ENG_OFF = 'h00,
  parameter logic [ADDR_W-1:0] CLK_OFF = 'h0C,
  parameter logic [ADDR_W-1:0] RES_OFF = 'h10,
  parameter logic [ADDR_W-1:0] TOP_OFF = 'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic [RES_W-1:0]  adcData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       engWord,
  input  logic [31:0]       clkWord,
  output logic [31:0]       rdData
);
  localparam int PAD_W  = 16 - RES_W;
  localparam int PAIRS  = NUM_CH / 2;
  localparam int PAIR_W = $clog2(PAIRS);
  localparam logic [ADDR_W-1:0] RES_END = RES_OFF + ADDR_W'(4 * PAIRS);

  logic [RES_W-1:0] res [NUM_CH];
  logic [31:0]      pairWord [PAIRS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) res[c] <= '0;
    end else if (strb.capture) begin
      res[strb.chan] <= adcData;
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : gPair
    assign pairWord[p] = {{PAD_W{1'b0}}, res[2*p+1], {PAD_W{1'b0}}, res[2*p]};
  end

  logic              rdHit;
  logic [ADDR_W-1:0] resOffs;
  logic [PAIR_W-1:0] pairSel;
  logic [31:0]       rdNext;

  assign rdHit   = (addr[1:0] == 2'b00) && (addr <= TOP_OFF);
  assign resOffs = addr - RES_OFF;
  assign pairSel = PAIR_W'(resOffs >> 2);

  always_comb begin
    rdNext = '0;
    if (rdHit) begin
      if (addr == ENG_OFF)                           rdNext = engWord;
      else if (addr == CLK_OFF)                      rdNext = clkWord;
      else if (addr >= RES_OFF && addr < RES_END)    rdNext = pairWord[pairSel];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top import adc_seq_pkg::*; #(
  parameter int ADDR_W     = 8,
  parameter int RES_W      = 10,
  parameter int PRE_W      = 15,
  parameter int PRE_LSB    = 17,
  parameter int SC_W       = 10,
  parameter int SLOT_TICKS = 12,
  parameter int INIT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              adcReq,
  output logic [CH_W-1:0]   adcChan,
  input  logic [RES_W-1:0]  adcData
);
  localparam logic [ADDR_W-1:0] ENG_OFF = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] CLK_OFF = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] RES_OFF = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] TOP_OFF = ADDR_W'('hC0);

  logic [31:0] engWord, clkWord;
  logic        engActive, engReady;
  seq_strobe_t seqStrb;

  adc_seq_ctrl #(
    .ADDR_W(ADDR_W), .PRE_W(PRE_W), .PRE_LSB(PRE_LSB), .SC_W(SC_W),
    .SLOT_TICKS(SLOT_TICKS), .INIT_TICKS(INIT_TICKS),
    .ENG_OFF(ENG_OFF), .CLK_OFF(CLK_OFF), .TOP_OFF(TOP_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .engWord(engWord), .clkWord(clkWord), .active(engActive), .initRdy(engReady),
    .strb(seqStrb), .adcReq(adcReq), .adcChan(adcChan)
  );

  adc_seq_data #(
    .ADDR_W(ADDR_W), .RES_W(RES_W), .ENG_OFF(ENG_OFF), .CLK_OFF(CLK_OFF),
    .RES_OFF(RES_OFF), .TOP_OFF(TOP_OFF)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(seqStrb), .adcData(adcData), .rdEn(regRdEn),
    .addr(regAddr), .engWord(engWord), .clkWord(clkWord), .rdData(regRdData)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker import adc_seq_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int RES_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              adcReq,
  input logic [CH_W-1:0]   adcChan,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdData,
  input logic              engActive,
  input logic              engReady,
  input logic              capture
);
  localparam logic [31:0] HALF = 32'((1 << RES_W) - 1);
  localparam logic [31:0] KEEP = HALF | (HALF << 16);

  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !engActive |=> !adcReq); // R4
  AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    adcReq |-> engReady); // R4
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !engActive |=> !engReady); // R5
  AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !adcReq); // R6
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (adcReq && $past(adcReq)) |-> $stable(adcChan)); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr[1:0] == 2'b00 && regAddr >= ADDR_W'('h10) && regAddr < ADDR_W'('h30))
    |=> ((regRdData & ~KEEP) == 32'h0)); // R8
endmodule

bind adc_seq_top adc_seq_checker #(.ADDR_W(ADDR_W), .RES_W(RES_W)) uChk (
  .clk(clk), .rstN(rstN), .adcReq(adcReq), .adcChan(adcChan),
  .regRdEn(regRdEn), .regAddr(regAddr), .regRdData(regRdData),
  .engActive(engActive), .engReady(engReady), .capture(seqStrb.capture)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        adcReq;
  logic [3:0]  adcChan;
  logic [9:0]  adcData;
  int          seed = 0;
  int          nChecks = 0, nErr = 0;

  always #10 clk = ~clk;

  function automatic logic [9:0] dataFor(input int ch, input int s);
    return 10'((ch * 41 + s) & 'h3FF);
  endfunction

  assign adcData = dataFor(int'(adcChan), seed);

  adc_seq_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .adcReq(adcReq), .adcChan(adcChan),
    .adcData(adcData)
  );

  // port monitor: channel at each rising request, width of each request
  int         logCnt = 0, runLen = 0, lastWidth = 0;
  logic [3:0] seqLog [256];
  logic       prevReq = 1'b0;
  always @(posedge clk) begin
    if (adcReq) begin
      if (!prevReq && logCnt < 256) begin
        seqLog[logCnt] = adcChan;
        logCnt++;
      end
      runLen++;
    end else if (runLen > 0) begin
      lastWidth = runLen;
      runLen = 0;
    end
    prevReq = adcReq;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); regRdEn = 1'b0; d = regRdData;
  endtask

  task automatic waitLog(input int target);
    for (int i = 0; i < 20000 && logCnt < target; i++) @(negedge clk);
    if (logCnt < target) begin
      nChecks++; nErr++;
      $display("FAIL R7: actual %0d requests expected %0d", logCnt, target);
    end
  endtask

  function automatic logic [31:0] pairExp(input logic [9:0] lo, input logic [9:0] hi);
    return {6'b0, hi, 6'b0, lo};
  endfunction

  task automatic testReset();
    logic [31:0] d;
    rdReg(8'h00, d); chk("R1 control word", d, 32'h0);
    rdReg(8'h0C, d); chk("R1 clock word", d, 32'h0);
    rdReg(8'h10, d); chk("R1 result 0/1", d, 32'h0);
    rdReg(8'h2C, d); chk("R1 result 14/15", d, 32'h0);
    chk("R1 request low", 32'(adcReq), 32'h0);
  endtask

  task automatic testFields();
    logic [31:0] d;
    wrReg(8'h00, 32'hFFFF_FFFE);
    rdReg(8'h00, d); chk("R2 control fields", d, 32'hFFFF_000E);
    wrReg(8'h00, 32'h0);
    wrReg(8'h0C, 32'hFFFF_FFFF);
    rdReg(8'h0C, d); chk("R3 clock fields", d, 32'hFFFE_03FF);
    wrReg(8'h0D, 32'h0);
    rdReg(8'h0C, d); chk("R11 misaligned write ignored", d, 32'hFFFE_03FF);
    rdReg(8'h0E, d); chk("R11 misaligned read", d, 32'h0);
    rdReg(8'h40, d); chk("R11 unmapped read", d, 32'h0);
    rdReg(8'hC4, d); chk("R11 beyond top read", d, 32'h0);
    wrReg(8'hCC, 32'hFFFF_FFFF);
    rdReg(8'h00, d); chk("R11 beyond top write ignored", d, 32'h0);
    wrReg(8'h0C, (32'd1 << 17) | 32'd1);
  endtask

  task automatic testStandby();
    logic [31:0] d;
    int base;
    base = logCnt;
    wrReg(8'h00, 32'h0001_0003);
    repeat (200) @(negedge clk);
    chk("R4 no request in standby", 32'(logCnt - base), 32'h0);
    rdReg(8'h00, d); chk("R4 standby not ready", d, 32'h0001_0003);
  endtask

  task automatic testReady();
    logic [31:0] d;
    wrReg(8'h00, 32'h0000_000F);
    rdReg(8'h00, d); chk("R5 ready clear early", d, 32'h0000_000F);
    repeat (40) @(negedge clk);
    rdReg(8'h00, d); chk("R5 ready set", d, 32'h0000_010F);
    wrReg(8'h00, 32'h0000_0003);
    repeat (2) @(negedge clk);
    rdReg(8'h00, d); chk("R5 ready cleared on exit", d, 32'h0000_0003);
  endtask

  task automatic testSparse();
    logic [31:0] d;
    int base;
    seed = 5;
    base = logCnt;
    wrReg(8'h00, 32'h8024_000F);
    waitLog(base + 5);
    chk("R7 order 0", 32'(seqLog[base]),   32'd2);
    chk("R7 order 1", 32'(seqLog[base+1]), 32'd5);
    chk("R7 order 2", 32'(seqLog[base+2]), 32'd15);
    chk("R7 wrap",    32'(seqLog[base+3]), 32'd2);
    chk("R6 width P1 S1", 32'(lastWidth), 32'd48);
    wrReg(8'h00, 32'h8024_0003);
    repeat (3) @(negedge clk);
    rdReg(8'h10, d); chk("R9 disabled 0/1", d, 32'h0);
    rdReg(8'h14, d); chk("R8 R9 ch2 ch3", d, pairExp(dataFor(2, 5), 10'h0));
    rdReg(8'h18, d); chk("R8 ch5", d, pairExp(10'h0, dataFor(5, 5)));
    rdReg(8'h2C, d); chk("R8 ch15", d, pairExp(10'h0, dataFor(15, 5)));
  endtask

  task automatic testHold();
    logic [31:0] d;
    int base;
    base = logCnt;
    seed = 100;
    repeat (300) @(negedge clk);
    rdReg(8'h14, d); chk("R10 hold in standby", d, pairExp(dataFor(2, 5), 10'h0));
    chk("R10 no request", 32'(logCnt - base), 32'h0);
    wrReg(8'h00, 32'h0);
    repeat (100) @(negedge clk);
    rdReg(8'h18, d); chk("R10 hold in power-down", d, pairExp(10'h0, dataFor(5, 5)));
  endtask

  task automatic testFull();
    logic [31:0] d;
    int base;
    wrReg(8'h0C, 32'h0);
    seed = 7;
    base = logCnt;
    wrReg(8'h00, 32'hFFFF_000F);
    waitLog(base + 17);
    chk("R7 full order 15", 32'(seqLog[base+15]), 32'd15);
    chk("R7 full wrap",     32'(seqLog[base+16]), 32'd0);
    chk("R6 width P0 S0", 32'(lastWidth), 32'd12);
    wrReg(8'h00, 32'hFFFF_0003);
    repeat (3) @(negedge clk);
    rdReg(8'h20, d); chk("R8 ch8 ch9", d, pairExp(dataFor(8, 7), dataFor(9, 7)));
  endtask

  task automatic testSingle();
    int base;
    wrReg(8'h00, 32'h0);
    wrReg(8'h0C, 32'd2 << 17);
    base = logCnt;
    wrReg(8'h00, 32'h0008_000F);
    waitLog(base + 2);
    chk("R6 width P2 S0", 32'(lastWidth), 32'd36);
    chk("R7 single channel", 32'(seqLog[base+1]), 32'd3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFields();
    testStandby();
    testReady();
    testSparse();
    testHold();
    testFull();
    testSingle();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule